// File: doc/BRIEF.md
# Debug Breakpoint Unit

This block sits beside a processor core and watches two streams. One is the program-counter stream, qualified by an instruction-fetch valid strobe. The other is the data-memory access stream, qualified by an access strobe and a read/write direction. When a configured condition matches, the block raises a one-cycle break request toward the halt logic. It also records the cause in a sticky status register. A debug host programs the block through a small register port.

The match resources come in four groups:

- A break when program flow is not sequential.
- A single-step break.
- Two comparators that only watch program addresses.
- Two shared comparators. Each shared comparator is set independently to watch either program addresses or data addresses. The two can also be joined into one value-plus-mask range breakpoint.

With these groups the host can build five layouts: four program points; three program points plus one data point; two program points plus two data points; two program points plus a program range; and two program points plus a data range.

The whole unit is active only when the debug strap is high and both lock inputs are low. Outside that condition it neither requests a break nor sets status.

Top module: `bkpt_unit`

## Requirements
- R1: With the flow-check bit (control bit 0) set, a valid fetch whose PC differs from the previously fetched PC plus one (modulo 2^PC_W) is a match. The first fetch after reset is never a flow match.
- R2: After the step bit (control bit 1) is written to 1, the first valid fetch does not match and the second valid fetch does. The step bit then reads back as 0, and later fetches do not match.
- R3: The two program comparators (enables at control bits 2 and 3, values in registers 1 and 2) match only in a cycle where the fetch strobe is high and the fetch PC equals the value. A cycle with no fetch strobe and no data strobe never leads to a break request.
- R4: A shared comparator enabled as a program comparator matches on a fetch whose PC equals its value, and ignores data accesses. The enables are control bits 4 and 5, the values are in registers 3 and 4, and the data-select bits are 6 and 7, written as 0 for program.
- R5: A shared comparator whose data-select bit is 1 matches a data access at its value only when the access direction is allowed by its read-select bit and write-select bit. These are control bits 9 and 10 for comparator 0, and bits 11 and 12 for comparator 1. A fetch never triggers it.
- R6: With the range bit (control bit 8) set, comparator 0 matches when ((addr XOR value0) AND value1) equals zero, where value1 is the mask held in register 4. Its kind and its direction selects come from the comparator 0 bits. Comparator 1 alone then never matches.
- R7: While the strap input is low, or either lock input is high, no break request is raised and no status bit is set. This holds even when a condition matches.
- R8: A match in the cycle before a clock edge gives brk_req high for exactly that one cycle after the edge. brk_req is low out of reset.
- R9: Status (register 5) holds one sticky bit per source: bit 0 flow, bit 1 step, bit 2 program 0, bit 3 program 1, bit 4 shared 0 or range, bit 5 shared 1. Writing 1 to a bit clears it, and a match in the same cycle as the clear wins.
- R10: Registers 0 to 5 read back on reg_rdata combinationally from reg_addr, and all of them reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en_strap | input | 1 | Debug enable strap |
| lock_a | input | 1 | First lock input; high disables the unit |
| lock_b | input | 1 | Second lock input; high disables the unit |
| fetch_vld | input | 1 | Instruction fetch valid strobe |
| fetch_pc | input | PC_W | Program counter of the fetched instruction |
| dacc_vld | input | 1 | Data-memory access strobe |
| dacc_wr | input | 1 | Access direction, 1 for write |
| dacc_addr | input | DA_W | Data-memory address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| brk_req | output | 1 | One-cycle break request |

## Verification
The bench uses the default build, with PC_W, DA_W and REG_W all at 16. At this width the range mask can be wider than one nibble, so a match can depend on the upper address bits alone. It also makes the all-ones address reachable as a stand-alone comparator-1 value, which shows comparator 1 being muted in range mode. A table checks the shared comparators in each of their roles. Directed sequences then cover flow checking, single-step, the enable gating, and a clear that collides with a new match.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    // Control register layout, bit 0 is flow_en
    typedef struct packed {
        logic c1_wr;
        logic c1_rd;
        logic c0_wr;
        logic c0_rd;
        logic range_on;
        logic c1_data;
        logic c0_data;
        logic c1_en;
        logic c0_en;
        logic p1_en;
        logic p0_en;
        logic step_en;
        logic flow_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Status bit indices
    localparam int SRC_FLOW = 0;
    localparam int SRC_STEP = 1;
    localparam int SRC_P0   = 2;
    localparam int SRC_P1   = 3;
    localparam int SRC_C0   = 4;
    localparam int SRC_C1   = 5;
    localparam int NSRC     = 6;

    // Register indices
    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_P0   = 3'd1;
    localparam logic [2:0] REG_P1   = 3'd2;
    localparam logic [2:0] REG_C0   = 3'd3;
    localparam logic [2:0] REG_C1   = 3'd4;
    localparam logic [2:0] REG_STAT = 3'd5;

    localparam int NCMP = 4;

endpackage

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_val,
    input  logic [AW-1:0] care,
    output logic          match
);
    always_comb begin
        match = (((addr ^ ref_val) & care) == '0);
    end
endmodule

// File: rtl/bkpt_flow_mon.sv
module bkpt_flow_mon #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            flow_en,
    input  logic            step_en,
    input  logic            fetch_vld,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            flow_hit,
    output logic            step_hit
);
    typedef struct packed {
        logic [PC_W-1:0] prev_pc;
        logic            have_prev;
        logic            step_seen;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d    = mon_q;
        flow_hit = 1'b0;
        step_hit = 1'b0;

        if (fetch_vld) begin
            flow_hit = en && flow_en && mon_q.have_prev &&
                       (fetch_pc != (mon_q.prev_pc + PC_W'(1)));
            mon_d.prev_pc   = fetch_pc;
            mon_d.have_prev = 1'b1;
        end

        if (!step_en) begin
            mon_d.step_seen = 1'b0;
        end else if (en && fetch_vld) begin
            step_hit        = mon_q.step_seen;
            mon_d.step_seen = !mon_q.step_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    // The step bit self-clears on a hit, so two hits never follow each other
    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_hit |=> !step_hit); // R2

    AST_FIRST_FETCH_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_q.have_prev) |-> !flow_hit); // R1

endmodule

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]  hit_set,
    input  logic             step_done,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] p0_val,
    output logic [REG_W-1:0] p1_val,
    output logic [REG_W-1:0] c0_val,
    output logic [REG_W-1:0] c1_val,
    output logic [NSRC-1:0]  status,
    output logic [REG_W-1:0] reg_rdata
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [REG_W-1:0] p0;
        logic [REG_W-1:0] p1;
        logic [REG_W-1:0] c0;
        logic [REG_W-1:0] c1;
        logic [NSRC-1:0]  stat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            unique case (reg_addr)
                REG_CTRL: cfg_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                REG_P0:   cfg_d.p0   = reg_wdata;
                REG_P1:   cfg_d.p1   = reg_wdata;
                REG_C0:   cfg_d.c0   = reg_wdata;
                REG_C1:   cfg_d.c1   = reg_wdata;
                REG_STAT: cfg_d.stat = cfg_q.stat & ~reg_wdata[NSRC-1:0];
                default:  ;
            endcase
        end
        if (step_done) cfg_d.ctrl.step_en = 1'b0;
        cfg_d.stat = cfg_d.stat | hit_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = REG_W'(cfg_q.ctrl);
            REG_P0:   reg_rdata = cfg_q.p0;
            REG_P1:   reg_rdata = cfg_q.p1;
            REG_C0:   reg_rdata = cfg_q.c0;
            REG_C1:   reg_rdata = cfg_q.c1;
            REG_STAT: reg_rdata = REG_W'(cfg_q.stat);
            default:  reg_rdata = '0;
        endcase
    end

    assign ctrl   = cfg_q.ctrl;
    assign p0_val = cfg_q.p0;
    assign p1_val = cfg_q.p1;
    assign c0_val = cfg_q.c0;
    assign c1_val = cfg_q.c1;
    assign status = cfg_q.stat;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_STAT) |=>
        ((cfg_q.stat & $past(reg_wdata[NSRC-1:0] & ~hit_set)) == '0)); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_set) |=> ((cfg_q.stat & $past(hit_set)) == $past(hit_set))); // R9

    AST_RANGE_MUTES_C1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ctrl.range_on && !cfg_q.stat[SRC_C1]) |=> !cfg_q.stat[SRC_C1]); // R6

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int DA_W  = 16,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en_strap,
    input  logic             lock_a,
    input  logic             lock_b,
    input  logic             fetch_vld,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             dacc_vld,
    input  logic             dacc_wr,
    input  logic [DA_W-1:0]  dacc_addr,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             brk_req
);
    localparam int CMP_W = (PC_W > DA_W) ? PC_W : DA_W;
    localparam logic [CMP_W-1:0] PC_CARE = CMP_W'({PC_W{1'b1}});
    localparam logic [CMP_W-1:0] DA_CARE = CMP_W'({DA_W{1'b1}});

    ctrl_t            ctrl;
    logic [REG_W-1:0] p0_val, p1_val, c0_val, c1_val;
    logic [NSRC-1:0]  status;
    logic [NSRC-1:0]  hit;
    logic             unit_en;
    logic             flow_hit, step_hit;

    logic [CMP_W-1:0] cmp_addr [NCMP];
    logic [CMP_W-1:0] cmp_ref  [NCMP];
    logic [CMP_W-1:0] cmp_care [NCMP];
    logic [NCMP-1:0]  cmp_match;

    typedef struct packed {
        logic brk;
    } out_t;

    out_t out_d, out_q;

    assign unit_en = dbg_en_strap && !lock_a && !lock_b;

    bkpt_cfg_regs #(.REG_W(REG_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hit_set   (hit),
        .step_done (hit[SRC_STEP]),
        .ctrl      (ctrl),
        .p0_val    (p0_val),
        .p1_val    (p1_val),
        .c0_val    (c0_val),
        .c1_val    (c1_val),
        .status    (status),
        .reg_rdata (reg_rdata)
    );

    bkpt_flow_mon #(.PC_W(PC_W)) mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (unit_en),
        .flow_en   (ctrl.flow_en),
        .step_en   (ctrl.step_en),
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .flow_hit  (flow_hit),
        .step_hit  (step_hit)
    );

    // Comparator operands: 0/1 dedicated program, 2/3 shared
    always_comb begin
        cmp_addr[0] = CMP_W'(fetch_pc);
        cmp_addr[1] = CMP_W'(fetch_pc);
        cmp_addr[2] = ctrl.c0_data ? CMP_W'(dacc_addr) : CMP_W'(fetch_pc);
        cmp_addr[3] = ctrl.c1_data ? CMP_W'(dacc_addr) : CMP_W'(fetch_pc);
        cmp_ref[0]  = p0_val[CMP_W-1:0];
        cmp_ref[1]  = p1_val[CMP_W-1:0];
        cmp_ref[2]  = c0_val[CMP_W-1:0];
        cmp_ref[3]  = c1_val[CMP_W-1:0];
        cmp_care[0] = PC_CARE;
        cmp_care[1] = PC_CARE;
        cmp_care[2] = (ctrl.c0_data ? DA_CARE : PC_CARE) &
                      (ctrl.range_on ? c1_val[CMP_W-1:0] : '1);
        cmp_care[3] = ctrl.c1_data ? DA_CARE : PC_CARE;
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        bkpt_addr_cmp #(.AW(CMP_W)) cmp_i (
            .addr    (cmp_addr[g]),
            .ref_val (cmp_ref[g]),
            .care    (cmp_care[g]),
            .match   (cmp_match[g])
        );
    end

    function automatic logic qual(input logic is_data, input logic rd_ok,
                                  input logic wr_ok, input logic f_vld,
                                  input logic d_vld, input logic d_wr);
        if (is_data) return d_vld && (d_wr ? wr_ok : rd_ok);
        return f_vld;
    endfunction

    always_comb begin
        hit           = '0;
        hit[SRC_FLOW] = flow_hit;
        hit[SRC_STEP] = step_hit;
        hit[SRC_P0]   = ctrl.p0_en && fetch_vld && cmp_match[0];
        hit[SRC_P1]   = ctrl.p1_en && fetch_vld && cmp_match[1];
        hit[SRC_C0]   = ctrl.c0_en && cmp_match[2] &&
                        qual(ctrl.c0_data, ctrl.c0_rd, ctrl.c0_wr,
                             fetch_vld, dacc_vld, dacc_wr);
        hit[SRC_C1]   = ctrl.c1_en && !ctrl.range_on && cmp_match[3] &&
                        qual(ctrl.c1_data, ctrl.c1_rd, ctrl.c1_wr,
                             fetch_vld, dacc_vld, dacc_wr);
        if (!unit_en) hit = '0;
        out_d.brk = |hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign brk_req = out_q.brk;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en_strap || lock_a || lock_b) |=> !brk_req); // R7

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_vld && !dacc_vld) |=> !brk_req); // R3

    AST_BRK_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (status != '0)); // R8

    AST_DISABLED_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_en && !reg_wr) |=> $stable(status)); // R7

endmodule

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb_top;
    import bkpt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en_strap = 1'b1;
    logic        lock_a = 1'b0;
    logic        lock_b = 1'b0;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        dacc_vld = 1'b0;
    logic        dacc_wr = 1'b0;
    logic [15:0] dacc_addr = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        brk_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bkpt_unit #(.PC_W(16), .DA_W(16), .REG_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_en_strap(dbg_en_strap),
        .lock_a(lock_a), .lock_b(lock_b), .fetch_vld(fetch_vld),
        .fetch_pc(fetch_pc), .dacc_vld(dacc_vld), .dacc_wr(dacc_wr),
        .dacc_addr(dacc_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_req(brk_req)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] c0;
        logic [15:0] c1;
        logic        is_fetch;
        logic        wr;
        logic [15:0] addr;
        logic        exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VT [NVEC] = '{
        '{16'h0010, 16'h0120, 16'h0000, 1'b1, 1'b0, 16'h0120, 1'b1}, // R4 prog hit
        '{16'h0010, 16'h0120, 16'h0000, 1'b1, 1'b0, 16'h0121, 1'b0}, // R4 miss
        '{16'h0010, 16'h0120, 16'h0000, 1'b0, 1'b0, 16'h0120, 1'b0}, // R4 data ignored
        '{16'h0250, 16'h0120, 16'h0000, 1'b0, 1'b0, 16'h0120, 1'b1}, // R5 read hit
        '{16'h0250, 16'h0120, 16'h0000, 1'b0, 1'b1, 16'h0120, 1'b0}, // R5 write blocked
        '{16'h0450, 16'h0120, 16'h0000, 1'b0, 1'b1, 16'h0120, 1'b1}, // R5 write hit
        '{16'h0110, 16'h0100, 16'hFF00, 1'b1, 1'b0, 16'h01AB, 1'b1}, // R6 prog range in
        '{16'h0110, 16'h0100, 16'hFF00, 1'b1, 1'b0, 16'h02AB, 1'b0}, // R6 prog range out
        '{16'h0750, 16'h0800, 16'hFFF0, 1'b0, 1'b1, 16'h080F, 1'b1}, // R6 data range in
        '{16'h0750, 16'h0800, 16'hFFF0, 1'b0, 1'b0, 16'h0810, 1'b0}, // R6 data range out
        '{16'h0130, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF, 1'b0}, // R6 c1 muted
        '{16'h0020, 16'h0000, 16'h0042, 1'b1, 1'b0, 16'h0042, 1'b1}  // R4 c1 prog hit
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fetch(input logic [15:0] pc);
        fetch_vld = 1'b1; fetch_pc = pc;
        @(negedge clk);
        fetch_vld = 1'b0;
    endtask

    task automatic daccess(input logic w, input logic [15:0] a);
        dacc_vld = 1'b1; dacc_wr = w; dacc_addr = a;
        @(negedge clk);
        dacc_vld = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R8, R10
        chk("R8 reset brk", brk_req, 0);
        rd_reg(REG_CTRL, rd); chk("R10 reset ctrl", rd, 0);
        rd_reg(REG_STAT, rd); chk("R10 reset status", rd, 0);
        rd_reg(REG_C1, rd);   chk("R10 reset c1", rd, 0);

        // Readback: R10
        wr_reg(REG_P1, 16'h1234);
        rd_reg(REG_P1, rd); chk("R10 readback", rd, 16'h1234);

        // Table for shared comparators: R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            wr_reg(REG_CTRL, VT[i].ctrl);
            wr_reg(REG_C0, VT[i].c0);
            wr_reg(REG_C1, VT[i].c1);
            wr_reg(REG_STAT, 16'h003F);
            if (VT[i].is_fetch) fetch(VT[i].addr);
            else                daccess(VT[i].wr, VT[i].addr);
            chk($sformatf("shared comparator table row %0d", i), brk_req, VT[i].exp);
        end

        // Dedicated comparator 0 with stall: R3
        wr_reg(REG_CTRL, 16'h0004);
        wr_reg(REG_P0, 16'h0050);
        wr_reg(REG_STAT, 16'h003F);
        fetch_pc = 16'h0050;
        @(negedge clk);
        chk("R3 stalled pc no match", brk_req, 0);
        fetch(16'h0050);
        chk("R3 p0 hit", brk_req, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", brk_req, 0);
        rd_reg(REG_STAT, rd); chk("R9 status p0 bit", rd, 16'h0004);
        wr_reg(REG_STAT, 16'h0001);
        rd_reg(REG_STAT, rd); chk("R9 other bit untouched", rd, 16'h0004);
        wr_reg(REG_STAT, 16'h0004);
        rd_reg(REG_STAT, rd); chk("R9 w1c cleared", rd, 16'h0000);

        // Dedicated comparator 1: R3
        wr_reg(REG_CTRL, 16'h0008);
        wr_reg(REG_P1, 16'h0077);
        fetch(16'h0076);
        chk("R3 p1 miss", brk_req, 0);
        fetch(16'h0077);
        chk("R3 p1 hit", brk_req, 1);
        rd_reg(REG_STAT, rd); chk("R9 status p1 bit", rd, 16'h0008);

        // Set wins over clear: R9
        wr_reg(REG_CTRL, 16'h0004);
        wr_reg(REG_STAT, 16'h003F);
        fetch_vld = 1'b1; fetch_pc = 16'h0050;
        reg_wr = 1'b1; reg_addr = REG_STAT; reg_wdata = 16'h0004;
        @(negedge clk);
        fetch_vld = 1'b0; reg_wr = 1'b0;
        chk("R9 collide brk", brk_req, 1);
        rd_reg(REG_STAT, rd); chk("R9 set wins", rd, 16'h0004);

        // Flow change: R1
        wr_reg(REG_CTRL, 16'h0001);
        fetch(16'h0010);
        wr_reg(REG_STAT, 16'h003F);
        fetch(16'h0011);
        chk("R1 sequential no break", brk_req, 0);
        fetch(16'h0012);
        chk("R1 sequential again", brk_req, 0);
        fetch(16'h0020);
        chk("R1 jump breaks", brk_req, 1);
        rd_reg(REG_STAT, rd); chk("R1 flow status", rd, 16'h0001);
        fetch(16'hFFFF);
        fetch(16'h0000);
        chk("R1 wrap is sequential", brk_req, 0);

        // Single step: R2
        wr_reg(REG_CTRL, 16'h0002);
        wr_reg(REG_STAT, 16'h003F);
        fetch(16'h0100);
        chk("R2 first fetch no break", brk_req, 0);
        fetch(16'h0101);
        chk("R2 second fetch breaks", brk_req, 1);
        rd_reg(REG_CTRL, rd); chk("R2 step bit cleared", rd, 16'h0000);
        rd_reg(REG_STAT, rd); chk("R2 step status", rd, 16'h0002);
        fetch(16'h0102);
        chk("R2 no further break", brk_req, 0);

        // Enable gating: R7
        wr_reg(REG_CTRL, 16'h0004);
        wr_reg(REG_STAT, 16'h003F);
        lock_a = 1'b1;
        fetch(16'h0050);
        chk("R7 lock_a blocks", brk_req, 0);
        lock_a = 1'b0; lock_b = 1'b1;
        fetch(16'h0050);
        chk("R7 lock_b blocks", brk_req, 0);
        lock_b = 1'b0; dbg_en_strap = 1'b0;
        fetch(16'h0050);
        chk("R7 strap low blocks", brk_req, 0);
        rd_reg(REG_STAT, rd); chk("R7 no status when off", rd, 16'h0000);
        dbg_en_strap = 1'b1;
        fetch(16'h0050);
        chk("R7 re-enabled hit", brk_req, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule